// File: doc/BRIEF.md
# Multiplexed Seven-Segment Serial Display Driver

This block scans eight common-cathode seven-segment digits through two chained 8-bit latched shift registers outside the chip. It uses three wires: serial data, serial clock and a latch strobe. The host writes one 7-bit lit-segment pattern per digit into a small internal register file. The block then sends one 16-bit frame per time slot. That frame holds a one-hot digit-select byte and a segment byte. The block raises the latch strobe so the external registers present both bytes at once, then waits out a hold interval before it serves the next digit.

Every frame is shifted most significant bit first, with the select byte ahead of the segment byte. After a full frame, the select byte therefore rests in the far register of the chain and the segment byte in the near one. The select bits are active high, because each common cathode is switched through an NPN transistor. The serial clock runs at the system clock divided by a parameter. Data moves while the serial clock is low and is sampled by the external registers on its rising edge. With the default 24 MHz system clock, each slot lasts about 2 ms, so all eight digits refresh at roughly 62 Hz.

Top module: `seg_scan_driver`

## Requirements
- R1: While reset is asserted, ser_clk, ser_data and latch_strobe are 0. The register file clears to all segments dark, so the first frame after reset carries a segment byte of 0x00.
- R2: Each frame is exactly 16 bits, sent most significant bit first. Bits 15..8 are the digit-select byte and bits 7..0 are the segment byte.
- R3: The select byte is one-hot and active high. Bit k is 1 when digit k is being served.
- R4: In the segment byte, bit 0 is segment a through bit 6 is segment g, with 1 meaning lit. Bit 7 is always 0.
- R5: ser_clk has a period of SCK_DIV system cycles, low for SCK_DIV/2 and high for SCK_DIV/2. ser_data changes only while ser_clk is low and holds steady while it is high.
- R6: Each frame has exactly 16 rising edges of ser_clk. latch_strobe rises only after the 16th, stays high for SCK_DIV/2 cycles, and ser_clk stays low while it is high.
- R7: Digits are served in the order 0, 1, … 7 and then wrap to 0, one digit per slot.
- R8: Successive rising edges of latch_strobe are exactly 1 + 16·SCK_DIV + SCK_DIV/2 + HOLD_CYCLES system cycles apart.
- R9: A write to the register file while a frame is being shifted does not change that frame. It takes effect from the next slot that serves the written digit.
- R10: A cycle with wr_en high stores wr_data as the pattern of digit wr_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Pattern write strobe |
| wr_addr | input | 3 | Digit index of the write |
| wr_data | input | 7 | Segment pattern, a in bit 0 to g in bit 6 |
| ser_data | output | 1 | Serial data to the first shift register |
| ser_clk | output | 1 | Serial shift clock |
| latch_strobe | output | 1 | Rising edge moves both shift registers into their output latches |

## Verification
A slot begins with one load cycle. The first frame bit is on ser_data in the next cycle, and each later bit follows SCK_DIV cycles after the one before. The first ser_clk rise comes SCK_DIV/2 cycles after its bit appears, and latch_strobe rises 1 + 16·SCK_DIV cycles after the slot begins. With HOLD_CYCLES shortened to 40, the bench expects a latch rise every 173 cycles. It samples at the falling system-clock edge and rebuilds each frame from the ser_clk rising edges it observes. It compares a whole frame against the head of its expected queue only on the latch_strobe rise that ends that frame, so a check does not depend on the cycle in which a single bit moves. The mid-frame write is issued after the first ser_clk rise of a frame has been observed, so the slot it must not disturb is known exactly.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    typedef enum logic [1:0] {
        SCAN_LOAD  = 2'd0,
        SCAN_SHIFT = 2'd1,
        SCAN_LATCH = 2'd2,
        SCAN_HOLD  = 2'd3
    } scan_state_e;

endpackage

// File: rtl/seg_pattern_store.sv
module seg_pattern_store #(
    parameter int DEPTH  = 8,
    parameter int WIDTH  = 7,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data
);

    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
                mem_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = (int'(rd_addr) < DEPTH) ? mem_q[rd_addr] : '0;

    // R10: a write becomes visible on the read port in the next cycle
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/seg_interval_timer.sv
module seg_interval_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = run && (tmr_q.cnt == CNT_LAST);
        if (!run || expire) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    generate
        if (LIMIT > 1) begin : g_chk
            // R8: an interval cannot end on two cycles in a row
            p_single_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
                expire |=> !expire);
        end
    endgenerate

endmodule

// File: rtl/seg_frame_serializer.sv
module seg_frame_serializer #(
    parameter int FRAME_W = 16,
    parameter int SCK_DIV = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               done,
    output logic               sck,
    output logic               sdo
);

    localparam int BIT_W = $clog2(FRAME_W);
    localparam int PH_W  = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SCK_DIV - 1);
    localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(SCK_DIV / 2);

    typedef struct packed {
        logic [FRAME_W-1:0] sreg;
        logic [BIT_W-1:0]   bit_cnt;
        logic [PH_W-1:0]    phase;
        logic               busy;
    } ser_regs_t;

    ser_regs_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        done  = 1'b0;
        if (!ser_q.busy) begin
            if (start) begin
                ser_d.sreg    = frame;
                ser_d.bit_cnt = '0;
                ser_d.phase   = '0;
                ser_d.busy    = 1'b1;
            end
        end else if (ser_q.phase == PH_LAST) begin
            ser_d.phase = '0;
            if (ser_q.bit_cnt == BIT_LAST) begin
                ser_d.busy = 1'b0;
                ser_d.sreg = '0;
                done       = 1'b1;
            end else begin
                ser_d.sreg    = {ser_q.sreg[FRAME_W-2:0], 1'b0};
                ser_d.bit_cnt = ser_q.bit_cnt + BIT_W'(1);
            end
        end else begin
            ser_d.phase = ser_q.phase + PH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q <= '0;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign sck = ser_q.busy && (ser_q.phase >= PH_HALF);
    assign sdo = ser_q.busy && ser_q.sreg[FRAME_W-1];

    // R2: a new frame is only accepted once the previous one has gone out
    p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !ser_q.busy);

    // R5: data holds while the serial clock is high
    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sdo));

endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver #(
    parameter int NUM_DIGITS  = 8,
    parameter int SEG_W       = 7,
    parameter int STAGE_W     = 8,
    parameter int SCK_DIV     = 8,
    parameter int HOLD_CYCLES = 48000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [6:0] wr_data,
    output logic       ser_data,
    output logic       ser_clk,
    output logic       latch_strobe
);

    import seg_scan_pkg::*;

    localparam int ADDR_W       = 3;
    localparam int FRAME_W      = 2 * STAGE_W;
    localparam int LATCH_CYCLES = SCK_DIV / 2;
    localparam logic [ADDR_W-1:0] DIG_LAST = ADDR_W'(NUM_DIGITS - 1);

    typedef struct packed {
        scan_state_e       state;
        logic [ADDR_W-1:0] digit;
    } scan_regs_t;

    scan_regs_t scan_d, scan_q;

    logic [SEG_W-1:0]   pattern;
    logic [STAGE_W-1:0] sel_vec;
    logic [FRAME_W-1:0] frame;
    logic               shift_start;
    logic               shift_done;
    logic               latch_run;
    logic               latch_exp;
    logic               hold_run;
    logic               hold_exp;

    seg_pattern_store #(
        .DEPTH  (NUM_DIGITS),
        .WIDTH  (SEG_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data[SEG_W-1:0]),
        .rd_addr (scan_q.digit),
        .rd_data (pattern)
    );

    generate
        for (genvar g = 0; g < STAGE_W; g++) begin : g_sel
            if (g < NUM_DIGITS) begin : g_live
                assign sel_vec[g] = (scan_q.digit == ADDR_W'(g));
            end else begin : g_pad
                assign sel_vec[g] = 1'b0;
            end
        end
    endgenerate

    assign frame = {sel_vec, {(STAGE_W - SEG_W){1'b0}}, pattern};

    seg_frame_serializer #(
        .FRAME_W (FRAME_W),
        .SCK_DIV (SCK_DIV)
    ) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .start (shift_start),
        .frame (frame),
        .done  (shift_done),
        .sck   (ser_clk),
        .sdo   (ser_data)
    );

    seg_interval_timer #(.LIMIT(LATCH_CYCLES)) u_latch_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (latch_run),
        .expire (latch_exp)
    );

    seg_interval_timer #(.LIMIT(HOLD_CYCLES)) u_hold_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (hold_run),
        .expire (hold_exp)
    );

    assign latch_run    = (scan_q.state == SCAN_LATCH);
    assign hold_run     = (scan_q.state == SCAN_HOLD);
    assign latch_strobe = latch_run;

    always_comb begin
        scan_d      = scan_q;
        shift_start = 1'b0;
        unique case (scan_q.state)
            SCAN_LOAD: begin
                shift_start  = 1'b1;
                scan_d.state = SCAN_SHIFT;
            end
            SCAN_SHIFT: begin
                if (shift_done) scan_d.state = SCAN_LATCH;
            end
            SCAN_LATCH: begin
                if (latch_exp) scan_d.state = SCAN_HOLD;
            end
            SCAN_HOLD: begin
                if (hold_exp) begin
                    scan_d.state = SCAN_LOAD;
                    scan_d.digit = (scan_q.digit == DIG_LAST) ? '0
                                 : scan_q.digit + ADDR_W'(1);
                end
            end
            default: scan_d.state = SCAN_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q.state <= SCAN_LOAD;
            scan_q.digit <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    // R6: the strobe is only raised by a completed frame
    p_latch_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_strobe) |-> $past(shift_done));

    // R6: no shift clock while the strobe is high
    p_latch_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_strobe |-> !ser_clk);

    // R3: the select byte handed to the serializer is one-hot
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_start |-> $onehot(frame[FRAME_W-1 -: STAGE_W]));

    // R7: each new slot serves the next digit, wrapping after the last
    p_digit_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_q.state == SCAN_LOAD && $past(scan_q.state) == SCAN_HOLD)
        |-> (scan_q.digit == (($past(scan_q.digit) == DIG_LAST) ? ADDR_W'(0)
                              : $past(scan_q.digit) + ADDR_W'(1))));

endmodule

// File: tb/tb_seg_scan_driver.sv
module tb_seg_scan_driver;

    localparam int HOLD   = 40;
    localparam int DIV    = 8;
    localparam int HALF   = DIV / 2;
    localparam int PERIOD = 1 + 16 * DIV + HALF + HOLD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [6:0] wr_data = '0;
    logic       ser_data, ser_clk, latch_strobe;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    seg_scan_driver #(.SCK_DIV(DIV), .HOLD_CYCLES(HOLD)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ser_data     (ser_data),
        .ser_clk      (ser_clk),
        .latch_strobe (latch_strobe)
    );

    logic [15:0] expq[$];

    function automatic logic [15:0] exp_frame(int d, logic [6:0] p);
        return {8'(1 << d), 1'b0, p};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor: rebuilds frames and times edges, compares at each strobe rise
    logic        prev_sck = 0, prev_latch = 0, prev_sdo = 0;
    logic [15:0] shreg = '0;
    int bitn = 0, hi_len = 0, lo_len = 0, latch_len = 0;
    int cyc = 0, last_latch = 0, frames_seen = 0;
    bit bad_duty = 0, bad_stable = 0, bad_latch_sck = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (ser_clk && prev_sck && ser_data !== prev_sdo) bad_stable = 1;
            if (ser_clk && !prev_sck) begin
                if (bitn > 0 && lo_len != HALF) bad_duty = 1;
                shreg = {shreg[14:0], ser_data};
                bitn++;
                hi_len = 1;
            end else if (ser_clk) begin
                hi_len++;
            end else if (prev_sck) begin
                if (hi_len != HALF) bad_duty = 1;
                lo_len = 1;
            end else begin
                lo_len++;
            end
            if (latch_strobe && ser_clk) bad_latch_sck = 1;
            if (latch_strobe && !prev_latch) begin
                chk(bitn == 16, "R6 edge count", bitn, 16);
                chk(!bad_duty, "R5 clock duty", bad_duty, 0);
                chk(!bad_stable, "R5 data stability", bad_stable, 0);
                if (expq.size() > 0) begin
                    logic [15:0] e;
                    e = expq.pop_front();
                    chk(shreg[15:8] == e[15:8], "R2 R3 R7 select byte", shreg[15:8], e[15:8]);
                    // first frame also covers R1 (blank after reset)
                    chk(shreg[7:0] == e[7:0], "R4 R9 R10 segment byte", shreg[7:0], e[7:0]);
                end
                if (frames_seen > 0)
                    chk(cyc - last_latch == PERIOD, "R8 slot period", cyc - last_latch, PERIOD);
                last_latch = cyc;
                frames_seen++;
                bitn = 0;
                bad_duty = 0;
                bad_stable = 0;
                latch_len = 1;
            end else if (latch_strobe) begin
                latch_len++;
            end else if (prev_latch) begin
                chk(latch_len == HALF, "R6 strobe width", latch_len, HALF);
                chk(!bad_latch_sck, "R6 clock low under strobe", bad_latch_sck, 0);
                bad_latch_sck = 0;
            end
            prev_sck   = ser_clk;
            prev_latch = latch_strobe;
            prev_sdo   = ser_data;
        end
    end

    task automatic wr(int a, logic [6:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    logic [6:0] pat [8] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07};

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle outputs under reset
        chk(ser_clk == 0, "R1 ser_clk in reset", ser_clk, 0);
        chk(ser_data == 0, "R1 ser_data in reset", ser_data, 0);
        chk(latch_strobe == 0, "R1 latch in reset", latch_strobe, 0);
        rst_n = 1'b1;
        expq.push_back(exp_frame(0, 7'h00));   // R1 cleared store
        for (int i = 0; i < 8; i++) wr(i, pat[i]);  // R10
        for (int k = 1; k < 16; k++) expq.push_back(exp_frame(k % 8, pat[k % 8]));
        wait (frames_seen == 16 && bitn >= 1);
        // R9: rewrite digits 0 and 1 while digit 0 is being shifted
        wr(0, 7'h7F);
        wr(1, 7'h6F);
        expq.push_back(exp_frame(0, pat[0]));
        expq.push_back(exp_frame(1, 7'h6F));
        for (int k = 2; k < 8; k++) expq.push_back(exp_frame(k, pat[k]));
        expq.push_back(exp_frame(0, 7'h7F));
        expq.push_back(exp_frame(1, 7'h6F));
        wait (frames_seen == 26);
        @(negedge clk);
        chk(expq.size() == 0, "R7 all slots served", expq.size(), 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

endmodule